// File: doc/BRIEF.md
# Nonvolatile Store and Recall Arbiter

This block decides when the contents of an SRAM are copied into nonvolatile cells (a store) and when they are copied back (a recall). It also controls when normal SRAM reads and writes are blocked around those transfers. A store can be asked for in four ways: by software, by an automatic trigger, by pulling a shared open-drain busy line low, or implicitly at power-up, which instead brings a recall. The block watches a write-strobe to learn whether the SRAM holds data that has not been saved. It uses that knowledge to skip automatic and line-requested stores that would write nothing new.

The shared line is modelled as two signals. A drive-low enable output pulls the line, and a sensed-level input is resynchronised through two flip-flops. Every transfer is a fixed sequence of phases. Each phase length is a parameter counted in clock cycles. A store runs an erase phase and then a program phase. A recall runs a clear phase and then a load phase.

The nonvolatile array and the analog voltage sensing sit outside the block. The block sees the voltage only through a synchronous voltage-good flag.

Top module: `nvxfer_arbiter`

## Requirements
- R1: An automatic store pulse starts a store only if the dirty latch is set. With the latch clear the pulse has no effect.
- R2: A software store pulse in the idle state always starts a store, whatever the dirty latch holds.
- R3: When the sensed line goes low in idle with the dirty latch set, the block enters a hold-off of T_DELAY cycles and then runs a store. During the hold-off, `rd_block`=0, `wr_block`=1 and `line_pull`=1.
- R4: When the sensed line goes low in idle with the dirty latch clear, the block never pulls the line. It holds `rd_block`=1 and `wr_block`=1 until the line is sensed high. Writes strobed in that time leave the dirty latch clear.
- R5: `line_pull` stays at 1 for every cycle of every store. It drops when the store ends. The block then keeps reads and writes blocked until the line is sensed high.
- R6: A store asserts `store_erase` for T_ERASE cycles and then `store_prog` for T_PROG cycles. Both block reads and writes. At most one of the four phase outputs is high in any cycle.
- R7: A software recall asserts `recall_clear` for T_RCLR cycles and then `recall_load` for T_RLOAD cycles, with `line_pull`=0. The block then returns to idle.
- R8: During reset and whenever `vgood`=0, reads and writes are blocked and no phase output is high. When `vgood` returns, the block runs a recall with T_RCLR clear cycles and T_HRLOAD load cycles and `line_pull`=1 throughout. It then waits for the line to be sensed high.
- R9: The dirty latch sets on a `wr_strobe` in a cycle where `wr_block`=0. It clears when any store or recall completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; treated as a power-up |
| vgood | input | 1 | Supply-good flag, synchronous to clk |
| wr_strobe | input | 1 | One-cycle SRAM write request from the host |
| sw_store | input | 1 | One-cycle software store trigger |
| sw_recall | input | 1 | One-cycle software recall trigger |
| auto_store | input | 1 | One-cycle automatic store trigger |
| line_in | input | 1 | Sensed level of the shared open-drain busy line, asynchronous |
| line_pull | output | 1 | 1 = drive the shared line low |
| rd_block | output | 1 | 1 = SRAM reads are inhibited |
| wr_block | output | 1 | 1 = SRAM writes are inhibited |
| store_erase | output | 1 | Store erase phase active |
| store_prog | output | 1 | Store program phase active |
| recall_clear | output | 1 | Recall SRAM-clear phase active |
| recall_load | output | 1 | Recall load phase active |

## Verification
A wrong dirty latch shows up as a store that runs or fails to run. The bench detects it within one trigger: an automatic pulse or a line pull-down after a known write history. A wrong phase counter shows up as phase outputs whose high-cycle totals differ from the parameters, and the bench counts these totals over each whole transfer. A wrong state after a store or an external pull-down leaves the read or write inhibits in the wrong level. The bench samples them a few cycles after the line is released, which is past the two-flop synchroniser delay.

// File: rtl/nvx_pkg.sv
package nvx_pkg;

  typedef enum logic [3:0] {
    S_OFF, S_IDLE, S_HOLD, S_ERASE, S_PROG,
    S_RCLR, S_RLOAD, S_WAITH, S_EXTB
  } nvx_state_e;

  typedef struct packed {
    logic pull;
    logic rd_blk;
    logic wr_blk;
    logic erase;
    logic prog;
    logic rclr;
    logic rload;
  } nvx_out_t;

  // Output levels for each state; hw selects line pull during recall.
  function automatic nvx_out_t nvx_decode(nvx_state_e s, logic hw);
    nvx_out_t o;
    o = '0;
    case (s)
      S_OFF:   begin o.rd_blk = 1'b1; o.wr_blk = 1'b1; end
      S_HOLD:  begin o.pull = 1'b1; o.wr_blk = 1'b1; end
      S_ERASE: begin o.pull = 1'b1; o.rd_blk = 1'b1; o.wr_blk = 1'b1; o.erase = 1'b1; end
      S_PROG:  begin o.pull = 1'b1; o.rd_blk = 1'b1; o.wr_blk = 1'b1; o.prog = 1'b1; end
      S_RCLR:  begin o.pull = hw; o.rd_blk = 1'b1; o.wr_blk = 1'b1; o.rclr = 1'b1; end
      S_RLOAD: begin o.pull = hw; o.rd_blk = 1'b1; o.wr_blk = 1'b1; o.rload = 1'b1; end
      S_WAITH, S_EXTB: begin o.rd_blk = 1'b1; o.wr_blk = 1'b1; end
      default: o = '0;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/nvx_sync2.sv
module nvx_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/nvx_timer.sv
module nvx_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= value;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/nvx_wlatch.sv
module nvx_wlatch (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  output logic dirty
);
  always_ff @(posedge clk) begin
    if (rst)          dirty <= 1'b0;
    else if (clr_req) dirty <= 1'b0;
    else if (set_req) dirty <= 1'b1;
  end
endmodule

// File: rtl/nvxfer_arbiter.sv
module nvxfer_arbiter
  import nvx_pkg::*;
#(
  parameter int T_DELAY  = 3,
  parameter int T_ERASE  = 4,
  parameter int T_PROG   = 5,
  parameter int T_RCLR   = 2,
  parameter int T_RLOAD  = 3,
  parameter int T_HRLOAD = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic vgood,
  input  logic wr_strobe,
  input  logic sw_store,
  input  logic sw_recall,
  input  logic auto_store,
  input  logic line_in,
  output logic line_pull,
  output logic rd_block,
  output logic wr_block,
  output logic store_erase,
  output logic store_prog,
  output logic recall_clear,
  output logic recall_load
);
  localparam int M1 = (T_DELAY > T_ERASE) ? T_DELAY : T_ERASE;
  localparam int M2 = (T_PROG > T_RCLR) ? T_PROG : T_RCLR;
  localparam int M3 = (T_RLOAD > T_HRLOAD) ? T_RLOAD : T_HRLOAD;
  localparam int M12 = (M1 > M2) ? M1 : M2;
  localparam int TMAX = (M12 > M3) ? M12 : M3;
  localparam int CW = (TMAX < 2) ? 1 : $clog2(TMAX);

  nvx_state_e state_q, state_d;
  logic       hw_q, hw_d;
  logic       line_s, dirty, tmr_zero, tmr_ld, done;
  logic [CW-1:0] tmr_val;
  nvx_out_t   o_q;

  nvx_sync2 #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(line_in), .q(line_s)
  );

  nvx_timer #(.W(CW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_ld), .value(tmr_val), .zero(tmr_zero)
  );

  nvx_wlatch u_wl (
    .clk(clk), .rst(rst),
    .set_req(wr_strobe && !o_q.wr_blk),
    .clr_req(done),
    .dirty(dirty)
  );

  always_comb begin
    state_d = state_q;
    hw_d    = hw_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    done    = 1'b0;
    case (state_q)
      S_OFF: begin
        state_d = S_RCLR; hw_d = 1'b1;
        tmr_ld = 1'b1; tmr_val = CW'(T_RCLR - 1);
      end
      S_IDLE: begin
        if (!line_s) begin
          if (dirty) begin
            state_d = S_HOLD; tmr_ld = 1'b1; tmr_val = CW'(T_DELAY - 1);
          end else begin
            state_d = S_EXTB;
          end
        end else if (sw_store || (auto_store && dirty)) begin
          state_d = S_ERASE; tmr_ld = 1'b1; tmr_val = CW'(T_ERASE - 1);
        end else if (sw_recall) begin
          state_d = S_RCLR; hw_d = 1'b0;
          tmr_ld = 1'b1; tmr_val = CW'(T_RCLR - 1);
        end
      end
      S_HOLD: if (tmr_zero) begin
        state_d = S_ERASE; tmr_ld = 1'b1; tmr_val = CW'(T_ERASE - 1);
      end
      S_ERASE: if (tmr_zero) begin
        state_d = S_PROG; tmr_ld = 1'b1; tmr_val = CW'(T_PROG - 1);
      end
      S_PROG: if (tmr_zero) begin
        state_d = S_WAITH; done = 1'b1;
      end
      S_RCLR: if (tmr_zero) begin
        state_d = S_RLOAD; tmr_ld = 1'b1;
        tmr_val = hw_q ? CW'(T_HRLOAD - 1) : CW'(T_RLOAD - 1);
      end
      S_RLOAD: if (tmr_zero) begin
        state_d = hw_q ? S_WAITH : S_IDLE; done = 1'b1;
      end
      S_WAITH, S_EXTB: if (line_s) state_d = S_IDLE;
      default: state_d = S_OFF;
    endcase
    if (!vgood) begin
      state_d = S_OFF; tmr_ld = 1'b0; done = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_OFF;
      hw_q    <= 1'b1;
      o_q     <= nvx_decode(S_OFF, 1'b1);
    end else begin
      state_q <= state_d;
      hw_q    <= hw_d;
      o_q     <= nvx_decode(state_d, hw_d);
    end
  end

  assign line_pull    = o_q.pull;
  assign rd_block     = o_q.rd_blk;
  assign wr_block     = o_q.wr_blk;
  assign store_erase  = o_q.erase;
  assign store_prog   = o_q.prog;
  assign recall_clear = o_q.rclr;
  assign recall_load  = o_q.rload;
endmodule

// File: rtl/nvx_checker.sv
module nvx_checker (
  input logic clk,
  input logic rst,
  input logic vgood,
  input logic line_pull,
  input logic rd_block,
  input logic wr_block,
  input logic store_erase,
  input logic store_prog,
  input logic recall_clear,
  input logic recall_load
);
  p_phase_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({store_erase, store_prog, recall_clear, recall_load}));

  p_prog_follows_erase_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(store_prog) |-> $past(store_erase));

  p_load_follows_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(recall_load) |-> $past(recall_clear));

  p_store_pulls_r5: assert property (@(posedge clk) disable iff (rst)
    (store_erase || store_prog) |-> line_pull);

  p_phase_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    (store_erase || store_prog || recall_clear || recall_load) |-> (rd_block && wr_block));

  p_vgood_low_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    !vgood |=> (rd_block && wr_block && !store_erase && !store_prog));

  p_rd_implies_wr_block_r3: assert property (@(posedge clk) disable iff (rst)
    rd_block |-> wr_block);
endmodule

bind nvxfer_arbiter nvx_checker u_chk (
  .clk(clk), .rst(rst), .vgood(vgood), .line_pull(line_pull),
  .rd_block(rd_block), .wr_block(wr_block), .store_erase(store_erase),
  .store_prog(store_prog), .recall_clear(recall_clear), .recall_load(recall_load)
);

// File: tb/sim_nvxfer_arbiter.sv
module sim_nvxfer_arbiter;
  localparam int TD = 3, TE = 4, TP = 5, TRC = 2, TRL = 3, THL = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vgood = 1'b0, wr_strobe = 1'b0, sw_store = 1'b0, sw_recall = 1'b0;
  logic auto_store = 1'b0, ext_pull = 1'b0;
  logic line_in, line_pull, rd_block, wr_block;
  logic store_erase, store_prog, recall_clear, recall_load;

  int checks = 0, errors = 0;
  int n_er, n_pg, n_rc, n_rl, n_pull, n_hold, cyc, first_er, first_pg;

  always #5 clk = ~clk;
  assign line_in = ~(line_pull | ext_pull);

  nvxfer_arbiter #(.T_DELAY(TD), .T_ERASE(TE), .T_PROG(TP),
                   .T_RCLR(TRC), .T_RLOAD(TRL), .T_HRLOAD(THL)) u0 (
    .clk(clk), .rst(rst), .vgood(vgood), .wr_strobe(wr_strobe),
    .sw_store(sw_store), .sw_recall(sw_recall), .auto_store(auto_store),
    .line_in(line_in), .line_pull(line_pull), .rd_block(rd_block),
    .wr_block(wr_block), .store_erase(store_erase), .store_prog(store_prog),
    .recall_clear(recall_clear), .recall_load(recall_load)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_counts();
    n_er = 0; n_pg = 0; n_rc = 0; n_rl = 0; n_pull = 0; n_hold = 0;
    cyc = 0; first_er = -1; first_pg = -1;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      cyc++;
      if (store_erase) begin n_er++; if (first_er < 0) first_er = cyc; end
      if (store_prog)  begin n_pg++; if (first_pg < 0) first_pg = cyc; end
      if (recall_clear) n_rc++;
      if (recall_load)  n_rl++;
      if (line_pull)    n_pull++;
      if (!rd_block && wr_block) n_hold++;
    end
  endtask

  task automatic pulse(input int which);
    case (which)
      0: wr_strobe = 1'b1;
      1: sw_store = 1'b1;
      2: sw_recall = 1'b1;
      default: auto_store = 1'b1;
    endcase
    run(1);
    wr_strobe = 1'b0; sw_store = 1'b0; sw_recall = 1'b0; auto_store = 1'b0;
  endtask

  task automatic chk_idle(input string req);
    chk({req, " rd_block idle"}, int'(rd_block), 0);
    chk({req, " wr_block idle"}, int'(wr_block), 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clr_counts();
    // R8: reset state blocks everything
    run(3);
    chk("R8 reset rd_block", int'(rd_block), 1);
    chk("R8 reset wr_block", int'(wr_block), 1);
    chk("R8 reset phases", int'(store_erase | store_prog | recall_clear | recall_load), 0);
    rst = 1'b0;
    run(3);
    chk("R8 vgood low blocks", int'(rd_block & wr_block), 1);
    chk("R8 vgood low no recall", n_rc, 0);
    // R8: power-up recall
    clr_counts(); vgood = 1'b1;
    run(30);
    chk("R8 hw recall clear cycles", n_rc, TRC);
    chk("R8 hw recall load cycles", n_rl, THL);
    chk("R8 hw recall pull cycles", n_pull, TRC + THL);
    chk("R8 no store at power-up", n_er + n_pg, 0);
    chk_idle("R8");

    // R1: auto store with clean latch does nothing
    clr_counts(); pulse(3); run(20);
    chk("R1 auto store clean latch", n_er + n_pg + n_pull, 0);
    chk_idle("R1");

    // R2: software store runs with clean latch
    clr_counts(); pulse(1); run(30);
    chk("R2 sw store erase cycles", n_er, TE);
    chk("R6 program cycles", n_pg, TP);
    chk("R6 erase before program", int'(first_er >= 0 && first_pg == first_er + TE), 1);
    chk("R5 pull over whole store", n_pull, TE + TP);
    chk_idle("R5");

    // R1 and R9: write sets latch, auto store then runs
    clr_counts(); pulse(0); run(2); pulse(3); run(30);
    chk("R1 auto store dirty erase", n_er, TE);
    chk("R1 auto store dirty prog", n_pg, TP);
    // R9: latch cleared by completed store
    clr_counts(); pulse(3); run(20);
    chk("R9 latch cleared after store", n_er + n_pg, 0);

    // R4: external pull-down with clean latch
    clr_counts(); ext_pull = 1'b1; run(6);
    chk("R4 block reads", int'(rd_block), 1);
    chk("R4 block writes", int'(wr_block), 1);
    pulse(0); run(3);
    chk("R4 no self pull", n_pull, 0);
    chk("R4 no store", n_er + n_pg, 0);
    ext_pull = 1'b0; run(5);
    chk_idle("R4");
    clr_counts(); pulse(3); run(20);
    chk("R4 write ignored while blocked", n_er + n_pg, 0);

    // R3 and R5: external pull-down with dirty latch
    clr_counts(); pulse(0); run(2);
    clr_counts(); ext_pull = 1'b1; run(30);
    chk("R3 hold-off cycles", n_hold, TD);
    chk("R3 store erase", n_er, TE);
    chk("R3 store prog", n_pg, TP);
    chk("R3 pull cycles", n_pull, TD + TE + TP);
    chk("R5 disabled after store", int'(rd_block & wr_block), 1);
    chk("R5 line released", int'(line_pull), 0);
    ext_pull = 1'b0; run(5);
    chk_idle("R5 after release");

    // R7: software recall, no pull, latch cleared
    clr_counts(); pulse(0); run(2); pulse(2); run(20);
    chk("R7 recall clear cycles", n_rc, TRC);
    chk("R7 recall load cycles", n_rl, TRL);
    chk("R7 recall no pull", n_pull, 0);
    chk_idle("R7");
    clr_counts(); pulse(3); run(20);
    chk("R9 latch cleared after recall", n_er + n_pg, 0);

    // R8: supply drop then return
    clr_counts(); pulse(0); run(2); vgood = 1'b0; run(3);
    chk("R8 drop blocks", int'(rd_block & wr_block), 1);
    clr_counts(); vgood = 1'b1; run(30);
    chk("R8 recall after drop clear", n_rc, TRC);
    chk("R8 recall after drop load", n_rl, THL);
    chk_idle("R8 after drop");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule